// File: doc/BRIEF.md
# Five-Bit Slot PWM Generator with Shutdown and Recall

This block turns a system clock into a pulse-width modulated square wave. Each output period has 32 equal slots, and each slot lasts `PRESCALE` system clocks. A five-bit duty code gives the number of slots per period in which the output is high. A separate full-on command holds the output high for the whole period. A shutdown command releases the pin by dropping the output-enable. A recall command brings back the output exactly as it was before the shutdown.

Each command has its own one-cycle load strobe. A command updates a pending configuration at once. The pending configuration moves into the active configuration only when the slot counter wraps from 31 to 0, so a change never cuts a pulse short or adds an extra edge. A status word reports the active duty code, the full-on flag and the shutdown flag.

Top module: `slot_pwm`

## Requirements
- R1: After reset the status word is 0x10, the output-enable is high, and the output is high for 16 × PRESCALE clocks of every 32 × PRESCALE clock period (50%).
- R2: With duty code n and full-on off, the output is high for exactly n × PRESCALE clocks per period. Code 0 keeps the output low for the whole period.
- R3: Code 31 gives 31 × PRESCALE high clocks per period, so at least one slot per period is low.
- R4: A full-on load keeps the output high for every clock of the period. A later duty load clears full-on, and the new code takes effect.
- R5: A new setting reaches the active configuration only on a slot-counter wrap (31 to 0). It shows on the status word and the output no later than two periods after the load.
- R6: A shutdown load drops the output-enable and holds the output low, and it sets status bit 7.
- R7: A recall load leaves shutdown and restores the setting held before shutdown, including full-on.
- R8: Duty and full-on loads made during shutdown update the stored setting and the status duty field. They do not drive the output until recall.
- R9: The status word has bit 7 for shutdown, bit 6 always 0, bit 5 for full-on and bits 4:0 for the active duty code.
- R10: When loads come in the same cycle, full-on wins over a duty load and shutdown wins over recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_val | input | 5 | Duty code for a duty load |
| duty_load | input | 1 | Load strobe for duty_val (clears full-on) |
| full_load | input | 1 | Strobe requesting 100% duty |
| sleep_load | input | 1 | Strobe requesting shutdown |
| wake_load | input | 1 | Strobe requesting recall from shutdown |
| pwm_out | output | 1 | Registered PWM level |
| pwm_oe | output | 1 | Registered output-enable; low means high impedance |
| status | output | 8 | Readback: [7] shutdown, [6] 0, [5] full-on, [4:0] duty |

## Verification
A load is captured into the pending setting at the next clock edge. It then waits at most one period, 32 × PRESCALE clocks, for a wrap to copy it into the active setting. The output register adds one more clock after that. So every result is due no later than 32 × PRESCALE + 2 clocks after the load. Each scenario therefore waits one period plus four clocks after its stimulus and then counts high and enabled clocks over exactly one full period, sampling on falling edges. The counts do not depend on where that window falls within the slot cycle. A separate latency check polls the status word clock by clock and requires the change within two periods.

// File: rtl/slot_pwm_pkg.sv
package slot_pwm_pkg;
  localparam int SLOT_W     = 5;
  localparam int NSLOT      = 1 << SLOT_W;
  localparam int STATUS_W   = 8;
  localparam logic [SLOT_W-1:0] RESET_DUTY = SLOT_W'(NSLOT / 2);

  typedef struct packed {
    logic              sleep;
    logic              full;
    logic [SLOT_W-1:0] duty;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{sleep: 1'b0, full: 1'b0, duty: RESET_DUTY};
endpackage

// File: rtl/slot_timebase.sv
module slot_timebase
  import slot_pwm_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot,
  output logic              wrap
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic tick;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PS_W-1:0] pcnt;
      always_ff @(posedge clk) begin
        if (rst)       pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + 1'b1;
      end
      assign tick = (pcnt == PS_W'(PRESCALE - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       slot <= '0;
    else if (tick) slot <= slot + 1'b1;
  end

  assign wrap = tick && (slot == '1);

  // R5: a wrap always lands the slot counter on zero
  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (slot == '0));
endmodule

// File: rtl/slot_cfg.sv
module slot_cfg
  import slot_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] duty_val,
  input  logic              duty_load,
  input  logic              full_load,
  input  logic              sleep_load,
  input  logic              wake_load,
  input  logic              wrap,
  output cfg_t              active
);
  cfg_t pend;

  // Later statements win: full over duty, sleep over wake (R10)
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= CFG_RESET;
    end else begin
      if (duty_load) begin
        pend.duty <= duty_val;
        pend.full <= 1'b0;
      end
      if (full_load)  pend.full  <= 1'b1;
      if (wake_load)  pend.sleep <= 1'b0;
      if (sleep_load) pend.sleep <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       active <= CFG_RESET;
    else if (wrap) active <= pend;
  end

  // R5: the active setting only moves on a period boundary
  p_hold_between_wraps_r5: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(active));
endmodule

// File: rtl/slot_pwm.sv
module slot_pwm
  import slot_pwm_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SLOT_W-1:0]   duty_val,
  input  logic                duty_load,
  input  logic                full_load,
  input  logic                sleep_load,
  input  logic                wake_load,
  output logic                pwm_out,
  output logic                pwm_oe,
  output logic [STATUS_W-1:0] status
);
  logic [SLOT_W-1:0] slot;
  logic              wrap;
  cfg_t              active;

  slot_timebase #(.PRESCALE(PRESCALE)) u_tb (
    .clk  (clk),
    .rst  (rst),
    .slot (slot),
    .wrap (wrap)
  );

  slot_cfg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .duty_val   (duty_val),
    .duty_load  (duty_load),
    .full_load  (full_load),
    .sleep_load (sleep_load),
    .wake_load  (wake_load),
    .wrap       (wrap),
    .active     (active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b0;
      pwm_oe  <= 1'b1;
    end else begin
      pwm_oe  <= !active.sleep;
      pwm_out <= !active.sleep && (active.full || (slot < active.duty));
    end
  end

  assign status = {active.sleep, 1'b0, active.full, active.duty};

  // R6: a released pin is never driven high
  p_sleep_low_r6: assert property (@(posedge clk) disable iff (rst)
    !pwm_oe |-> !pwm_out);
  // R2: code zero without full-on keeps the output low
  p_zero_low_r2: assert property (@(posedge clk) disable iff (rst)
    (active.duty == '0 && !active.full) |=> !pwm_out);
  // R4: full-on while awake keeps the output high
  p_full_high_r4: assert property (@(posedge clk) disable iff (rst)
    (active.full && !active.sleep) |=> pwm_out);
  // R9: reserved status bit stays clear
  p_status_rsv_r9: assert property (@(posedge clk) disable iff (rst)
    !status[6]);
endmodule

// File: tb/slot_pwm_tb.sv
module slot_pwm_tb;
  localparam int P   = 4;
  localparam int PER = 32 * P;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] duty_val = '0;
  logic       duty_load = 1'b0, full_load = 1'b0, sleep_load = 1'b0, wake_load = 1'b0;
  logic       pwm_out, pwm_oe;
  logic [7:0] status;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  slot_pwm #(.PRESCALE(P)) u_dut (
    .clk(clk), .rst(rst), .duty_val(duty_val), .duty_load(duty_load),
    .full_load(full_load), .sleep_load(sleep_load), .wake_load(wake_load),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .status(status)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [4:0] d, input logic dl, input logic fl,
                       input logic sl, input logic wl);
    @(negedge clk);
    duty_val = d; duty_load = dl; full_load = fl; sleep_load = sl; wake_load = wl;
    @(negedge clk);
    duty_load = 0; full_load = 0; sleep_load = 0; wake_load = 0;
  endtask

  task automatic settle();
    repeat (PER + 4) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int en);
    hi = 0; en = 0;
    repeat (PER) begin
      @(negedge clk);
      if (pwm_out) hi++;
      if (pwm_oe)  en++;
    end
  endtask

  task automatic t_reset();
    int hi, en;
    check("R1 status", int'(status), 8'h10);
    check("R1 oe", int'(pwm_oe), 1);
    repeat (2) @(negedge clk);
    measure(hi, en);
    check("R1 high", hi, 16 * P);
    check("R1 enabled", en, PER);
  endtask

  task automatic t_duty(input string req, input int code);
    int hi, en;
    pulse(5'(code), 1, 0, 0, 0);
    settle();
    measure(hi, en);
    check({req, " high"}, hi, code * P);
    check({req, " status"}, int'(status), code);
  endtask

  task automatic t_full();
    int hi, en;
    pulse(5'd0, 0, 1, 0, 0);
    settle();
    measure(hi, en);
    check("R4 full high", hi, PER);
    check("R4 full status", int'(status), 8'h25);
    pulse(5'd7, 1, 0, 0, 0);
    settle();
    measure(hi, en);
    check("R4 duty cancels full", hi, 7 * P);
    check("R4 status after cancel", int'(status), 8'h07);
  endtask

  task automatic t_latency();
    int lat, hi, en;
    pulse(5'd12, 1, 0, 0, 0);
    lat = 0;
    while (status[4:0] != 5'd12 && lat <= 2 * PER) begin
      @(negedge clk);
      lat++;
    end
    check("R5 latency within two periods", int'(lat <= 2 * PER), 1);
    settle();
    measure(hi, en);
    check("R5 output after update", hi, 12 * P);
  endtask

  task automatic t_sleep();
    int hi, en;
    pulse(5'd0, 0, 0, 1, 0);
    settle();
    measure(hi, en);
    check("R6 sleep high", hi, 0);
    check("R6 sleep oe", en, 0);
    check("R6 R9 sleep status", int'(status), 8'h8C);
  endtask

  task automatic t_write_in_sleep();
    int hi, en;
    pulse(5'd9, 1, 0, 0, 0);
    settle();
    measure(hi, en);
    check("R8 stays off high", hi, 0);
    check("R8 stays off oe", en, 0);
    check("R8 stored duty status", int'(status), 8'h89);
    pulse(5'd0, 0, 0, 0, 1);
    settle();
    measure(hi, en);
    check("R8 new duty after wake", hi, 9 * P);
    check("R8 oe after wake", en, PER);
  endtask

  task automatic t_recall_full();
    int hi, en;
    pulse(5'd0, 0, 1, 0, 0);
    settle();
    pulse(5'd0, 0, 0, 1, 0);
    settle();
    measure(hi, en);
    check("R7 off during sleep", en, 0);
    pulse(5'd0, 0, 0, 0, 1);
    settle();
    measure(hi, en);
    check("R7 full restored", hi, PER);
    check("R7 status", int'(status), 8'h29);
  endtask

  task automatic t_simultaneous();
    int hi, en;
    pulse(5'd3, 1, 1, 0, 0);
    settle();
    measure(hi, en);
    check("R10 full wins high", hi, PER);
    check("R10 full wins status", int'(status), 8'h23);
    pulse(5'd0, 0, 0, 1, 1);
    settle();
    measure(hi, en);
    check("R10 sleep wins oe", en, 0);
    check("R10 sleep wins status", int'(status[7]), 1);
    pulse(5'd0, 0, 0, 0, 1);
    settle();
    measure(hi, en);
    check("R10 wake after", hi, PER);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_duty("R2 code0", 0);
    t_duty("R3 code31", 31);
    t_duty("R2 code5", 5);
    t_full();
    t_latency();
    t_sleep();
    t_write_in_sleep();
    t_recall_full();
    t_simultaneous();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule